// File: doc/BRIEF.md
# Fused Threshold Binarizer for Binary Network Layers

This block turns each signed integer convolution result into one binary activation bit. It does so without running the normalization and piecewise-linear activation arithmetic that training used. Off-line, that chain (an affine scale-and-offset followed by a leaky rectifier with a learned negative slope and a sign function) is folded into two integer thresholds per output channel: one for non-negative inputs and one for negative inputs. A direction bit for each threshold says whether the folded scale for that branch is negative. When it is set, the comparison runs the other way.

Results arrive on a valid/ready stream, each tagged with its output-channel index. The sign of the result picks which threshold and which direction bit of that channel apply. The block then emits a bit where 1 encodes +1 and 0 encodes −1, and that bit feeds the next binary convolution. A write port loads the thresholds and direction bits of one channel per cycle. There is a single output register, so the latency is one cycle, and a stalled consumer stops the input side.

Top module: `bnn_thresh_binarizer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Every channel holds both thresholds at 0 and both direction bits at 0, so a non-negative input yields 1 and a negative input yields 0.
- R2: An input x ≥ 0 uses the channel's positive-branch threshold Tp. With the positive direction bit at 0, the output bit is 1 exactly when x ≥ Tp.
- R3: An input x < 0 (sign bit set) uses the channel's negative-branch threshold Tn. With the negative direction bit at 0, the output bit is 1 exactly when x ≥ Tn.
- R4: When the direction bit of the selected branch is 1, the output bit is 1 exactly when x ≤ T. This holds for both branches.
- R5: An input equal to the selected threshold yields 1, whatever the direction bit.
- R6: An input accepted at a clock edge (in_valid and in_ready both high) appears on out_valid/out_bit right after that edge. With out_ready high, an output is removed at the next edge unless a new input replaces it.
- R7: While out_valid is 1 and out_ready is 0, out_bit holds its value, out_valid stays 1 and in_ready is 0.
- R8: Each accepted input produces exactly one output bit, and the bits come out in the order the inputs were accepted, including back-to-back inputs and inputs that waited through a stall.
- R9: A configuration write (cfg_we) to a channel does not affect an input of that channel accepted at the same edge. It applies to inputs accepted at later edges.
- R10: A configuration write changes only the addressed channel. All other channels keep their thresholds and direction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input result is valid |
| in_ready | output | 1 | Block can accept an input |
| in_data | input | ACC_W | Signed convolution result |
| in_ch | input | CH_W | Output-channel index of the result |
| out_valid | output | 1 | Output bit is valid |
| out_ready | input | 1 | Consumer takes the output bit |
| out_bit | output | 1 | Binary activation, 1 = +1, 0 = −1 |
| cfg_we | input | 1 | Write strobe for one channel's parameters |
| cfg_ch | input | CH_W | Channel being written |
| cfg_thr_pos | input | ACC_W | Signed threshold for non-negative inputs |
| cfg_thr_neg | input | ACC_W | Signed threshold for negative inputs |
| cfg_inv_pos | input | 1 | Direction bit for the non-negative branch (1 = compare x ≤ T) |
| cfg_inv_neg | input | 1 | Direction bit for the negative branch (1 = compare x ≤ T) |

## Verification
The bench sits on each threshold and one step either side of it, in both branches and both directions. A design that compares strictly, or that swaps the direction sense, fails at the exact equality points. It drives the extreme signed values and a zero input, which catch a design that picks the branch by an unsigned compare or treats zero as negative. A write that lands in the same cycle as an input of that channel exposes a design that forwards the new threshold too early. A stall lasting several cycles, with a second input waiting, shows whether the output bit gets overwritten or lost, and whether the two bits come out in the wrong order.

// File: rtl/bnn_thresh_binarizer.sv
module bnn_thresh_binarizer #(
  parameter int ACC_W = 16,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ACC_W-1:0] in_data,
  input  logic [CH_W-1:0]  in_ch,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic [ACC_W-1:0] cfg_thr_pos,
  input  logic [ACC_W-1:0] cfg_thr_neg,
  input  logic             cfg_inv_pos,
  input  logic             cfg_inv_neg
);
  localparam int NUM_CH = 1 << CH_W;

  logic [ACC_W-1:0] thr_pos_q [NUM_CH];
  logic [ACC_W-1:0] thr_neg_q [NUM_CH];
  logic [NUM_CH-1:0] inv_pos_q, inv_neg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        thr_pos_q[i] <= '0;
        thr_neg_q[i] <= '0;
      end
      inv_pos_q <= '0;
      inv_neg_q <= '0;
    end else if (cfg_we) begin
      thr_pos_q[cfg_ch] <= cfg_thr_pos;
      thr_neg_q[cfg_ch] <= cfg_thr_neg;
      inv_pos_q[cfg_ch] <= cfg_inv_pos;
      inv_neg_q[cfg_ch] <= cfg_inv_neg;
    end
  end

  wire                    is_neg = in_data[ACC_W-1];
  wire signed [ACC_W-1:0] x      = in_data;
  wire signed [ACC_W-1:0] thr    = is_neg ? thr_neg_q[in_ch] : thr_pos_q[in_ch];
  wire                    inv    = is_neg ? inv_neg_q[in_ch] : inv_pos_q[in_ch];
  wire                    decide = inv ? (x <= thr) : (x >= thr);

  assign in_ready = !out_valid || out_ready;
  wire accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (accept) out_bit <= decide;
    end
  end
endmodule

module bnn_thresh_binarizer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit
);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));

  a_r7_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r6_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !in_valid |=> !out_valid);
endmodule

bind bnn_thresh_binarizer bnn_thresh_binarizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
);

// File: tb/bnn_thresh_binarizer_test.sv
module bnn_thresh_binarizer_test;
  localparam int ACC_W = 16;
  localparam int CH_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [ACC_W-1:0] in_data = '0;
  logic [CH_W-1:0] in_ch = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_bit;
  logic cfg_we = 1'b0;
  logic [CH_W-1:0] cfg_ch = '0;
  logic [ACC_W-1:0] cfg_thr_pos = '0, cfg_thr_neg = '0;
  logic cfg_inv_pos = 1'b0, cfg_inv_neg = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bnn_thresh_binarizer #(.ACC_W(ACC_W), .CH_W(CH_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ch(in_ch), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .cfg_we(cfg_we),
    .cfg_ch(cfg_ch), .cfg_thr_pos(cfg_thr_pos), .cfg_thr_neg(cfg_thr_neg),
    .cfg_inv_pos(cfg_inv_pos), .cfg_inv_neg(cfg_inv_neg)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int tp, input int tn, input bit ip, input bit in_);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CH_W'(ch);
    cfg_thr_pos = ACC_W'(tp); cfg_thr_neg = ACC_W'(tn);
    cfg_inv_pos = ip; cfg_inv_neg = in_;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input int x, input int ch, input bit exp, input string tag);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_data = ACC_W'(x); in_ch = CH_W'(ch);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, int'(out_valid), 1);
    check({tag, " bit"}, int'(out_bit), int'(exp));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    push(5, 0, 1'b1, "R1 pos");
    push(-3, 0, 1'b0, "R1 neg");
    push(0, 0, 1'b1, "R1 zero");
    push(32767, 0, 1'b1, "R1 max");
    push(-32768, 0, 1'b0, "R1 min");
  endtask

  task automatic t_normal;
    cfg(1, 100, -50, 1'b0, 1'b0);
    push(99, 1, 1'b0, "R2 below");
    push(100, 1, 1'b1, "R5 pos eq");
    push(101, 1, 1'b1, "R2 above");
    push(-51, 1, 1'b0, "R3 below");
    push(-50, 1, 1'b1, "R5 neg eq");
    push(-10, 1, 1'b1, "R3 above");
    push(0, 1, 1'b0, "R2 zero uses pos");
  endtask

  task automatic t_invert;
    cfg(2, 20, -7, 1'b1, 1'b1);
    push(20, 2, 1'b1, "R5 inv pos eq");
    push(21, 2, 1'b0, "R4 inv pos above");
    push(5, 2, 1'b1, "R4 inv pos below");
    push(-7, 2, 1'b1, "R5 inv neg eq");
    push(-6, 2, 1'b0, "R4 inv neg above");
    push(-100, 2, 1'b1, "R4 inv neg below");
  endtask

  task automatic t_isolation;
    push(99, 1, 1'b0, "R10 ch1 kept below");
    push(100, 1, 1'b1, "R10 ch1 kept eq");
    push(0, 3, 1'b1, "R10 ch3 reset pos");
    push(-1, 3, 1'b0, "R10 ch3 reset neg");
  endtask

  task automatic t_cfg_timing;
    @(negedge clk);
    out_ready = 1'b1;
    cfg_we = 1'b1; cfg_ch = 4'd4; cfg_thr_pos = 16'd50; cfg_thr_neg = '0;
    cfg_inv_pos = 1'b0; cfg_inv_neg = 1'b0;
    in_valid = 1'b1; in_data = 16'd10; in_ch = 4'd4;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R9 same-cycle valid", int'(out_valid), 1);
    check("R9 same-cycle old thr", int'(out_bit), 1);
    push(10, 4, 1'b0, "R9 next uses new thr");
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 16'd101; in_ch = 4'd1;
    @(posedge clk);
    @(negedge clk);
    check("R6 first valid", int'(out_valid), 1);
    check("R7 first bit", int'(out_bit), 1);
    check("R7 ready low", int'(in_ready), 0);
    in_data = 16'd99; in_ch = 4'd1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R7 held valid", int'(out_valid), 1);
      check("R7 held bit", int'(out_bit), 1);
      check("R7 ready held low", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second valid", int'(out_valid), 1);
    check("R8 second bit", int'(out_bit), 0);
    @(posedge clk);
    @(negedge clk);
    check("R8 drained", int'(out_valid), 0);
  endtask

  task automatic t_burst;
    push(-50, 1, 1'b1, "R8 burst a");
    push(-51, 1, 1'b0, "R8 burst b");
    push(21, 2, 1'b0, "R8 burst c");
    push(20, 2, 1'b1, "R8 burst d");
    @(posedge clk);
    @(negedge clk);
    check("R6 drain after burst", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_normal;
    t_invert;
    t_isolation;
    t_cfg_timing;
    t_stall;
    t_burst;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule